// File: doc/BRIEF.md
# ROM Download Word Writer

This block sits between a loader that streams a ROM image and a 16-bit, word-addressed memory write port, such as one port of an SDRAM controller. The loader presents data beats with a valid/ready handshake while a download-active level is high. The block keeps a byte-granular download address and turns each beat into one memory word write. The memory sees a word address, write data and two byte-lane strobes, held under a request until the memory acknowledges.

A `WIDE` parameter picks the loader width. With `WIDE=1` each beat carries two bytes. The byte at the even address arrives in the low half of the beat, so the block swaps the halves and a big-endian 16-bit reader sees the image in file order. With `WIDE=0` each beat is one byte, and the block pairs consecutive bytes into one word before writing. If an odd number of bytes is sent, the last byte is written when the download ends, using only the upper lane.

The download address is a byte address. The memory word address is that byte address with bit 0 dropped, so consecutive words land in consecutive memory words with none skipped.

Top module: `rom_dl_writer`

## Requirements
- R1: On a rising edge of `dl_active` the byte address returns to 0, so the first word of every download is written to memory word address 0.
- R2: The byte address advances by 2 per accepted beat when WIDE=1 and by 1 when WIDE=0; the word address of a write is the byte address of its first byte shifted right by one.
- R3: With WIDE=1, `mem_wdata` is `{in_data[7:0], in_data[15:8]}`: the low input byte (even address) goes to bits 15:8.
- R4: Every write made from a full word has both `mem_we_hi` (bits 15:8) and `mem_we_lo` (bits 7:0) high.
- R5: With WIDE=0, two consecutive bytes form one write: the even-address byte in bits 15:8, the odd-address byte in bits 7:0; an even-address byte alone causes no write.
- R6: `in_ready` is low while `dl_active` is low, in the first cycle after its rising edge, and while `mem_req` is high; `mem_req`, `mem_addr`, `mem_wdata` and the strobes stay unchanged until a cycle with `mem_ack` high.
- R7: `dl_done` is 0 after reset, clears on a rising edge of `dl_active`, and rises only after `dl_active` has fallen and every write, including a trailing one, has been acknowledged.
- R8: With WIDE=0 and an odd byte count, after `dl_active` falls the held byte is written to its word with data `{byte, 8'h00}`, `mem_we_hi`=1 and `mem_we_lo`=0, leaving bits 7:0 of that memory word unchanged.
- R9: An image starting 00 FF FF 00 00 00 02 08 reads back by word address as 0x00FF, 0xFF00, 0x0000, 0x0208, i.e. a big-endian pointer pair 0x00FFFF00 and 0x00000208.
- R10: A beat offered while `in_ready` is low is not taken: it changes neither the address nor the memory contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_active | input | 1 | High for the length of a download |
| in_valid | input | 1 | Loader beat valid |
| in_data | input | 16 if WIDE=1, else 8 | Loader beat data |
| in_ready | output | 1 | Block accepts the beat in this cycle |
| mem_req | output | 1 | Memory write request, held until acknowledged |
| mem_addr | output | ADDR_W-1 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we_hi | output | 1 | Write strobe for bits 15:8 |
| mem_we_lo | output | 1 | Write strobe for bits 7:0 |
| mem_ack | input | 1 | Memory has taken the request |
| dl_done | output | 1 | Download finished and all writes acknowledged |

## Verification
The bench runs a wide and a narrow instance against a memory model whose acknowledge latency varies, and compares every write with a queue of expected writes built from the image bytes. A design that fed the byte address straight to memory would leave every other word untouched and fail the readback; one without the swap would return 0xFF00 for the first word. A second wide download checks that the address restarts at zero rather than continuing past the first image. The narrow run ends on an odd byte, so a design that dropped the trailing byte, or wrote its lower lane, leaves the pre-filled pattern wrong in that word. Beats held valid while a write is pending catch a design that takes the same beat twice.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

  // Put the even-address byte (arriving in the low half) into the upper half.
  function automatic logic [15:0] swap_lanes(input logic [15:0] beat);
    return {beat[7:0], beat[15:8]};
  endfunction

  // Big-endian pairing of two bytes from the stream.
  function automatic logic [15:0] pack_pair(input logic [7:0] even_b, input logic [7:0] odd_b);
    return {even_b, odd_b};
  endfunction

  // Bytes covered by one accepted beat.
  function automatic int unsigned beat_bytes(input bit wide);
    return wide ? 2 : 1;
  endfunction

endpackage

// File: rtl/rdw_byte_counter.sv
module rdw_byte_counter #(
  parameter bit WIDE   = 1'b1,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [ADDR_W-1:0] byte_addr
);
  import rdw_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(beat_bytes(WIDE));

  always_ff @(posedge clk) begin
    if (!rst_n)       byte_addr <= '0;
    else if (clear)   byte_addr <= '0;
    else if (advance) byte_addr <= byte_addr + STEP;
  end

  // R1: the cycle after a download starts, the address is zero
  a_r1_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> byte_addr == '0);

endmodule

// File: rtl/rdw_word_builder.sv
module rdw_word_builder #(
  parameter bit WIDE   = 1'b1,
  parameter int ADDR_W = 24,
  localparam int DW    = WIDE ? 16 : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat,
  input  logic              flush_ok,
  input  logic [DW-1:0]     in_data,
  input  logic [ADDR_W-1:0] byte_addr,
  output logic              wr_fire,
  output logic [ADDR_W-2:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic              holding
);
  import rdw_pkg::*;

  // Word address: drop the byte-select bit.
  assign wr_addr = byte_addr[ADDR_W-1:1];

  generate
    if (WIDE) begin : g_wide
      assign wr_fire = beat;
      assign wr_data = swap_lanes(in_data);
      assign wr_hi   = 1'b1;
      assign wr_lo   = 1'b1;
      assign holding = 1'b0;
      logic unused_wide;
      assign unused_wide = ^{clk, rst_n, clear, flush_ok, byte_addr[0]};
    end else begin : g_narrow
      logic [7:0] held_byte;
      logic       held_q;
      logic       pair_fire;
      logic       tail_fire;

      assign pair_fire = beat & byte_addr[0];
      assign tail_fire = flush_ok & held_q & ~clear;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          held_q    <= 1'b0;
          held_byte <= '0;
        end else if (clear) begin
          held_q    <= 1'b0;
        end else if (beat && !byte_addr[0]) begin
          held_q    <= 1'b1;
          held_byte <= in_data;
        end else if (pair_fire || tail_fire) begin
          held_q    <= 1'b0;
        end
      end

      assign wr_fire = pair_fire | tail_fire;
      assign wr_data = pair_fire ? pack_pair(held_byte, in_data) : pack_pair(held_byte, 8'h00);
      assign wr_hi   = 1'b1;
      assign wr_lo   = pair_fire;
      assign holding = held_q;

      // R8: a trailing byte never writes the lower lane
      a_r8_tail_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
        tail_fire |-> wr_hi && !wr_lo && !beat);
      // R5: a pair completes only with a byte already held
      a_r5_pair_needs_held: assert property (@(posedge clk) disable iff (!rst_n)
        pair_fire |-> held_q);
    end
  endgenerate

endmodule

// File: rtl/rdw_write_port.sv
module rdw_write_port #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-2:0] addr_in,
  input  logic [15:0]       data_in,
  input  logic              hi_in,
  input  logic              lo_in,
  input  logic              ack,
  output logic              req,
  output logic [ADDR_W-2:0] addr,
  output logic [15:0]       data,
  output logic              we_hi,
  output logic              we_lo
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req   <= 1'b0;
      addr  <= '0;
      data  <= '0;
      we_hi <= 1'b0;
      we_lo <= 1'b0;
    end else if (fire) begin
      req   <= 1'b1;
      addr  <= addr_in;
      data  <= data_in;
      we_hi <= hi_in;
      we_lo <= lo_in;
    end else if (ack) begin
      req   <= 1'b0;
    end
  end

  // R6: a new write never arrives over a pending one
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !req);
  // R6: request and payload held until acknowledged
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(addr) && $stable(data) && $stable(we_hi) && $stable(we_lo));

endmodule

// File: rtl/rom_dl_writer.sv
module rom_dl_writer #(
  parameter bit WIDE   = 1'b1,
  parameter int ADDR_W = 24,
  localparam int DW    = WIDE ? 16 : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dl_active,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready,
  output logic              mem_req,
  output logic [ADDR_W-2:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              mem_we_hi,
  output logic              mem_we_lo,
  input  logic              mem_ack,
  output logic              dl_done
);
  import rdw_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(beat_bytes(WIDE));

  logic              active_q;
  logic              dl_rise;
  logic              dl_fall;
  logic              beat;
  logic [ADDR_W-1:0] byte_addr;
  logic              wr_fire;
  logic [ADDR_W-2:0] wr_addr;
  logic [15:0]       wr_data;
  logic              wr_hi;
  logic              wr_lo;
  logic              holding;
  logic              finish_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= dl_active;
  end

  assign dl_rise  = dl_active & ~active_q;
  assign dl_fall  = ~dl_active & active_q;
  assign in_ready = dl_active & active_q & ~mem_req;
  assign beat     = in_valid & in_ready;

  rdw_byte_counter #(.WIDE(WIDE), .ADDR_W(ADDR_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (dl_rise),
    .advance   (beat),
    .byte_addr (byte_addr)
  );

  rdw_word_builder #(.WIDE(WIDE), .ADDR_W(ADDR_W)) u_build (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (dl_rise),
    .beat      (beat),
    .flush_ok  (~dl_active & ~mem_req),
    .in_data   (in_data),
    .byte_addr (byte_addr),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .holding   (holding)
  );

  rdw_write_port #(.ADDR_W(ADDR_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (wr_fire),
    .addr_in (wr_addr),
    .data_in (wr_data),
    .hi_in   (wr_hi),
    .lo_in   (wr_lo),
    .ack     (mem_ack),
    .req     (mem_req),
    .addr    (mem_addr),
    .data    (mem_wdata),
    .we_hi   (mem_we_hi),
    .we_lo   (mem_we_lo)
  );

  // Completion: wait for the fall, then for the builder and port to drain.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      finish_pend <= 1'b0;
      dl_done     <= 1'b0;
    end else if (dl_rise) begin
      finish_pend <= 1'b0;
      dl_done     <= 1'b0;
    end else if (dl_fall) begin
      finish_pend <= 1'b1;
    end else if (finish_pend && !mem_req && !holding && !wr_fire) begin
      finish_pend <= 1'b0;
      dl_done     <= 1'b1;
    end
  end

  // R6: never ready while a write is outstanding
  a_r6_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);
  // R7: done only with the write port idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dl_done |-> !mem_req);
  // R2: each accepted beat moves the address by the beat size
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> byte_addr == $past(byte_addr) + STEP);
  // R10: a refused beat leaves the address alone
  a_r10_refused_beat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && !dl_rise |=> $stable(byte_addr));

endmodule

// File: tb/test_rom_dl_writer.sv
`timescale 1ns/1ps
module test_rom_dl_writer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // wide instance
  logic        w_dl = 0, w_valid = 0, w_ready, w_req, w_hi, w_lo, w_ack = 0, w_done;
  logic [15:0] w_data = '0, w_wdata;
  logic [22:0] w_addr;
  // narrow instance
  logic        n_dl = 0, n_valid = 0, n_ready, n_req, n_hi, n_lo, n_ack = 0, n_done;
  logic [7:0]  n_data = '0;
  logic [15:0] n_wdata;
  logic [22:0] n_addr;

  rom_dl_writer #(.WIDE(1'b1), .ADDR_W(24)) i_rom_dl_writer (
    .clk(clk), .rst_n(rst_n), .dl_active(w_dl), .in_valid(w_valid), .in_data(w_data),
    .in_ready(w_ready), .mem_req(w_req), .mem_addr(w_addr), .mem_wdata(w_wdata),
    .mem_we_hi(w_hi), .mem_we_lo(w_lo), .mem_ack(w_ack), .dl_done(w_done));

  rom_dl_writer #(.WIDE(1'b0), .ADDR_W(24)) i_rom_dl_writer_narrow (
    .clk(clk), .rst_n(rst_n), .dl_active(n_dl), .in_valid(n_valid), .in_data(n_data),
    .in_ready(n_ready), .mem_req(n_req), .mem_addr(n_addr), .mem_wdata(n_wdata),
    .mem_we_hi(n_hi), .mem_we_lo(n_lo), .mem_ack(n_ack), .dl_done(n_done));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural memories and expected-write queues
  logic [15:0] wmem [0:63];
  logic [15:0] nmem [0:63];
  logic [22:0] wq_addr[$], nq_addr[$];
  logic [15:0] wq_data[$], nq_data[$];
  logic [1:0]  wq_be[$],   nq_be[$];
  int w_wait = 0, n_wait = 0, lat_seed = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(!(w_req && w_ready), "R6", "wide ready during pending write", {31'd0, w_ready}, 32'd0);
      check(!(n_req && n_ready), "R6", "narrow ready during pending write", {31'd0, n_ready}, 32'd0);
    end
    if (w_ack) w_ack = 1'b0;
    else if (w_req) begin
      if (w_wait == 0) begin
        if (wq_addr.size() == 0) check(1'b0, "R10", "wide unexpected write", {9'd0, w_addr}, 32'd0);
        else begin
          check(w_addr == wq_addr[0], "R2", "wide word address", {9'd0, w_addr}, {9'd0, wq_addr[0]});
          check(w_wdata == wq_data[0], "R3", "wide swapped data", {16'd0, w_wdata}, {16'd0, wq_data[0]});
          check({w_hi, w_lo} == wq_be[0], "R4", "wide strobes", {30'd0, w_hi, w_lo}, {30'd0, wq_be[0]});
          void'(wq_addr.pop_front()); void'(wq_data.pop_front()); void'(wq_be.pop_front());
        end
        if (w_hi) wmem[w_addr[5:0]][15:8] = w_wdata[15:8];
        if (w_lo) wmem[w_addr[5:0]][7:0]  = w_wdata[7:0];
        w_ack = 1'b1;
        lat_seed++; w_wait = lat_seed % 3;
      end else w_wait--;
    end
    if (n_ack) n_ack = 1'b0;
    else if (n_req) begin
      if (n_wait == 0) begin
        if (nq_addr.size() == 0) check(1'b0, "R10", "narrow unexpected write", {9'd0, n_addr}, 32'd0);
        else begin
          check(n_addr == nq_addr[0], "R2", "narrow word address", {9'd0, n_addr}, {9'd0, nq_addr[0]});
          check(n_wdata == nq_data[0], "R5", "narrow packed data", {16'd0, n_wdata}, {16'd0, nq_data[0]});
          check({n_hi, n_lo} == nq_be[0], "R8", "narrow strobes", {30'd0, n_hi, n_lo}, {30'd0, nq_be[0]});
          void'(nq_addr.pop_front()); void'(nq_data.pop_front()); void'(nq_be.pop_front());
        end
        if (n_hi) nmem[n_addr[5:0]][15:8] = n_wdata[15:8];
        if (n_lo) nmem[n_addr[5:0]][7:0]  = n_wdata[7:0];
        n_ack = 1'b1;
        lat_seed++; n_wait = (lat_seed * 2) % 3;
      end else n_wait--;
    end
  end

  // Host side
  int w_byte = 0, n_byte = 0;
  logic [7:0] n_even = '0;

  task automatic put_w(input logic [7:0] even_b, input logic [7:0] odd_b);
    logic r;
    @(negedge clk);
    w_valid = 1'b1; w_data = {odd_b, even_b};
    wq_addr.push_back(23'(w_byte / 2)); wq_data.push_back({even_b, odd_b}); wq_be.push_back(2'b11);
    w_byte += 2;
    forever begin #1 r = w_ready; @(posedge clk); if (r) break; @(negedge clk); end
  endtask

  task automatic put_n(input logic [7:0] b);
    logic r;
    @(negedge clk);
    n_valid = 1'b1; n_data = b;
    if (n_byte % 2 == 0) n_even = b;
    else begin
      nq_addr.push_back(23'(n_byte / 2)); nq_data.push_back({n_even, b}); nq_be.push_back(2'b11);
    end
    n_byte++;
    forever begin #1 r = n_ready; @(posedge clk); if (r) break; @(negedge clk); end
  endtask

  task automatic wait_done_w();
    @(negedge clk); w_valid = 1'b0; w_dl = 1'b0;
    @(negedge clk);
    check(w_done == 1'b0, "R7", "wide done too early", {31'd0, w_done}, 32'd0);
    for (int i = 0; i < 40 && !w_done; i++) @(negedge clk);
    check(w_done == 1'b1, "R7", "wide done raised", {31'd0, w_done}, 32'd1);
    check(wq_addr.size() == 0 && !w_req, "R7", "wide writes drained at done", wq_addr.size(), 32'd0);
  endtask

  task automatic wait_done_n();
    @(negedge clk); n_valid = 1'b0; n_dl = 1'b0;
    if (n_byte % 2 == 1) begin
      nq_addr.push_back(23'(n_byte / 2)); nq_data.push_back({n_even, 8'h00}); nq_be.push_back(2'b10);
    end
    @(negedge clk);
    check(n_done == 1'b0, "R7", "narrow done too early", {31'd0, n_done}, 32'd0);
    for (int i = 0; i < 40 && !n_done; i++) @(negedge clk);
    check(n_done == 1'b1, "R7", "narrow done raised", {31'd0, n_done}, 32'd1);
    check(nq_addr.size() == 0 && !n_req, "R8", "trailing byte written before done", nq_addr.size(), 32'd0);
  endtask

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  logic [7:0] img [0:15];

  initial begin
    img[0]=8'h00; img[1]=8'hFF; img[2]=8'hFF; img[3]=8'h00;
    img[4]=8'h00; img[5]=8'h00; img[6]=8'h02; img[7]=8'h08;
    img[8]=8'h4E; img[9]=8'h71; img[10]=8'h4E; img[11]=8'h75;
    img[12]=8'h12; img[13]=8'h34; img[14]=8'hAB; img[15]=8'hCD;
    for (int i = 0; i < 64; i++) begin wmem[i] = 16'hFEFE; nmem[i] = 16'hFEFE; end

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(!w_ready && !w_req && !w_done, "R7", "wide reset outputs", {29'd0, w_ready, w_req, w_done}, 32'd0);
    check(!n_ready && !n_req && !n_done, "R7", "narrow reset outputs", {29'd0, n_ready, n_req, n_done}, 32'd0);

    // R10: beats before the download are refused
    n_valid = 1'b1; n_data = 8'h5A;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!n_ready && !n_req, "R10", "idle beat refused", {30'd0, n_ready, n_req}, 32'd0);
    end
    n_valid = 1'b0;

    // Wide download 1 (R1..R4, R9)
    @(negedge clk); w_dl = 1'b1; w_byte = 0;
    #1 check(!w_ready, "R6", "ready low in start cycle", {31'd0, w_ready}, 32'd0);
    for (int k = 0; k < 8; k++) put_w(img[2*k], img[2*k+1]);
    wait_done_w();
    for (int k = 0; k < 8; k++)
      check(wmem[k] == {img[2*k], img[2*k+1]}, "R9", "wide readback word", {16'd0, wmem[k]}, {16'd0, img[2*k], img[2*k+1]});
    check({wmem[0], wmem[1]} == 32'h00FFFF00, "R9", "stack pointer", {wmem[0], wmem[1]}, 32'h00FFFF00);
    check({wmem[2], wmem[3]} == 32'h00000208, "R9", "entry address", {wmem[2], wmem[3]}, 32'h00000208);
    check(wmem[8] == 16'hFEFE, "R2", "no write past image", {16'd0, wmem[8]}, 32'h0000FEFE);

    // Wide download 2: address restarts at zero (R1)
    @(negedge clk); w_dl = 1'b1; w_byte = 0;
    #1 check(w_done == 1'b1, "R7", "done holds until rise seen", {31'd0, w_done}, 32'd1);
    @(negedge clk);
    check(w_done == 1'b0, "R7", "done cleared by new download", {31'd0, w_done}, 32'd0);
    put_w(8'h11, 8'h22);
    put_w(8'h33, 8'h44);
    wait_done_w();
    check(wmem[0] == 16'h1122, "R1", "restart word 0", {16'd0, wmem[0]}, 32'h00001122);
    check(wmem[1] == 16'h3344, "R1", "restart word 1", {16'd0, wmem[1]}, 32'h00003344);
    check(wmem[2] == 16'h0000, "R1", "word 2 untouched", {16'd0, wmem[2]}, 32'h00000000);

    // Narrow download, odd length (R5, R8)
    @(negedge clk); n_dl = 1'b1; n_byte = 0;
    for (int k = 0; k < 7; k++) put_n(img[k]);
    wait_done_n();
    check(nmem[0] == 16'h00FF, "R5", "narrow word 0", {16'd0, nmem[0]}, 32'h000000FF);
    check(nmem[1] == 16'hFF00, "R5", "narrow word 1", {16'd0, nmem[1]}, 32'h0000FF00);
    check(nmem[2] == 16'h0000, "R5", "narrow word 2", {16'd0, nmem[2]}, 32'h00000000);
    check(nmem[3] == 16'h02FE, "R8", "trailing byte keeps lower lane", {16'd0, nmem[3]}, 32'h000002FE);
    check(nmem[4] == 16'hFEFE, "R2", "narrow no write past image", {16'd0, nmem[4]}, 32'h0000FEFE);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule